// File: doc/BRIEF.md
# Auto-Negotiation Link Pulse Burst Generator

This block produces the periodic pulse bursts that an Ethernet transceiver sends during link auto-negotiation. Each burst is a sequence of fixed timing slots. A clock pulse opens every slot. A data pulse may sit inside the slot, at a fixed offset after the clock pulse. That data pulse is present when the matching bit of a parallel code word is 1 and absent when the bit is 0. A final clock pulse closes the burst. Bursts repeat at a fixed period for as long as the enable is held.

All timing is expressed in system-clock cycles through parameters. These are the pulse width, the offset from a clock pulse to its data pulse, the slot length and the burst period. The default values assume a 50 MHz clock: a pulse of about 100 ns, a 60 µs data offset, 125 µs slots and a 15 ms period. The code word is captured when a burst begins, so software or an arbiter may change it at any time without corrupting a burst that is already on the line. The two transmit outputs idle at equal levels. A pulse is a positive difference between them. A separate flag marks the span of each burst.

Top module: `flp_burst_gen`

## Requirements
- R1: While reset is asserted, both transmit outputs and the burst flag are 0.
- R2: A burst consists of WORD_BITS slots of SLOT_CYC cycles followed by one closing pulse. Every slot starts with a clock pulse in which the positive output is 1 for PULSE_CYC cycles. Consecutive clock pulses therefore start exactly SLOT_CYC cycles apart.
- R3: In slot i (i = 0 for the first slot), bit i of the captured word is used, so bits go out least significant first. If that bit is 1, the positive output is also 1 for PULSE_CYC cycles starting DATA_OFS_CYC cycles after the slot start. If the bit is 0, the output stays 0 for the rest of the slot.
- R4: The code word is captured on the clock edge that starts a burst. Changes to the code word input during a burst do not alter that burst's pulses.
- R5: The burst flag is 1 from the first cycle of the opening clock pulse through the last cycle of the closing clock pulse. That span is WORD_BITS*SLOT_CYC + PULSE_CYC cycles.
- R6: When the enable is first seen high with the period timer at rest, a burst begins on the next clock edge. While the enable stays high, successive bursts begin exactly PERIOD_CYC cycles apart.
- R7: If the enable is deasserted during a burst, that burst still runs to completion. No further burst starts while the enable stays low.
- R8: The negative output is always 0. Outside a burst, the positive output is 0, so the difference between the outputs is zero.
- R9: A burst holds WORD_BITS+1 clock pulses plus one data pulse per 1 bit. With the default of 14 bits, this gives 15 to 29 pulses for any word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Allows bursts to be generated |
| code_word_i | input | WORD_BITS | Word to encode; captured at burst start |
| tx_p_o | output | 1 | Positive transmit level, 1 during a pulse |
| tx_n_o | output | 1 | Negative transmit level, held at idle |
| burst_active_o | output | 1 | High from first to last pulse of a burst |

## Verification
The words sent cover several corners. An all-zero word leaves only clock pulses. An all-one word fills every data position. Alternating patterns catch a swapped bit order or an off-by-one slot. A lone set bit at the least and at the most significant position pins the end slots. Random words then cover the remaining space. While each burst runs, the code word input is overwritten with random values, so any failure to capture the word shows up as a wrong data pulse. The enable is held steady to measure the burst period, dropped in mid-burst to show that the burst completes and nothing follows, and toggled at random to exercise restarts from a resting timer.

// File: rtl/flp_pkg.sv
package flp_pkg;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_BURST = 1'b1
    } flp_state_e;

endpackage

// File: rtl/flp_period_timer.sv
module flp_period_timer #(
    parameter int PERIOD_CYC = 750000
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic enable_i,
    output logic start_o
);
    localparam int CNT_W = $clog2(PERIOD_CYC);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PERIOD_CYC - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (tmr_q.cnt == '0 && !enable_i) begin
            tmr_d.cnt = '0;
        end else if (tmr_q.cnt == CNT_LAST) begin
            tmr_d.cnt = '0;
        end else begin
            tmr_d.cnt = tmr_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign start_o = enable_i && (tmr_q.cnt == '0);

    // R6
    period_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tmr_q.cnt == CNT_LAST) |=> (tmr_q.cnt == '0));

endmodule

// File: rtl/flp_burst_seq.sv
module flp_burst_seq
    import flp_pkg::*;
#(
    parameter int WORD_BITS    = 14,
    parameter int PULSE_CYC    = 5,
    parameter int DATA_OFS_CYC = 3000,
    parameter int SLOT_CYC     = 6250
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 start_i,
    input  logic [WORD_BITS-1:0] word_i,
    output logic                 pulse_o,
    output logic                 active_o
);
    localparam int POS_W  = $clog2(SLOT_CYC);
    localparam int SLOT_W = $clog2(WORD_BITS + 1);
    localparam logic [POS_W-1:0]  POS_LAST   = POS_W'(SLOT_CYC - 1);
    localparam logic [POS_W-1:0]  PULSE_LAST = POS_W'(PULSE_CYC - 1);
    localparam logic [POS_W-1:0]  PULSE_END  = POS_W'(PULSE_CYC);
    localparam logic [POS_W-1:0]  DATA_LO    = POS_W'(DATA_OFS_CYC);
    localparam logic [POS_W-1:0]  DATA_HI    = POS_W'(DATA_OFS_CYC + PULSE_CYC);
    localparam logic [SLOT_W-1:0] SLOT_END   = SLOT_W'(WORD_BITS);

    typedef struct packed {
        flp_state_e            state;
        logic [POS_W-1:0]      pos;
        logic [SLOT_W-1:0]     slot;
        logic [WORD_BITS-1:0]  word;
        logic                  pulse;
    } seq_t;

    seq_t seq_d, seq_q;
    logic [WORD_BITS-1:0] shifted_d;
    logic                 data_bit_d;

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    seq_d.state = ST_BURST;
                    seq_d.pos   = '0;
                    seq_d.slot  = '0;
                    seq_d.word  = word_i;
                end
            end
            ST_BURST: begin
                if (seq_q.slot == SLOT_END && seq_q.pos == PULSE_LAST) begin
                    seq_d.state = ST_IDLE;
                    seq_d.pos   = '0;
                    seq_d.slot  = '0;
                end else if (seq_q.pos == POS_LAST) begin
                    seq_d.pos  = '0;
                    seq_d.slot = seq_q.slot + 1'b1;
                end else begin
                    seq_d.pos = seq_q.pos + 1'b1;
                end
            end
            default: seq_d.state = ST_IDLE;
        endcase

        shifted_d  = seq_d.word >> seq_d.slot;
        data_bit_d = shifted_d[0] && (seq_d.slot != SLOT_END);
        seq_d.pulse = (seq_d.state == ST_BURST) &&
                      ((seq_d.pos < PULSE_END) ||
                       (data_bit_d && seq_d.pos >= DATA_LO && seq_d.pos < DATA_HI));
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign pulse_o  = seq_q.pulse;
    assign active_o = (seq_q.state == ST_BURST);

    // R4
    word_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (seq_q.state == ST_BURST && $past(seq_q.state == ST_BURST)) |-> $stable(seq_q.word));

    // R6
    no_overlap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start_i |-> (seq_q.state == ST_IDLE));

    // R2
    slot_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        seq_q.slot <= SLOT_END);

endmodule

// File: rtl/flp_burst_gen.sv
module flp_burst_gen #(
    parameter int WORD_BITS    = 14,
    parameter int PULSE_CYC    = 5,
    parameter int DATA_OFS_CYC = 3000,
    parameter int SLOT_CYC     = 6250,
    parameter int PERIOD_CYC   = 750000
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 enable_i,
    input  logic [WORD_BITS-1:0] code_word_i,
    output logic                 tx_p_o,
    output logic                 tx_n_o,
    output logic                 burst_active_o
);
    logic start_s;

    flp_period_timer #(
        .PERIOD_CYC (PERIOD_CYC)
    ) timer_i (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .enable_i (enable_i),
        .start_o  (start_s)
    );

    flp_burst_seq #(
        .WORD_BITS    (WORD_BITS),
        .PULSE_CYC    (PULSE_CYC),
        .DATA_OFS_CYC (DATA_OFS_CYC),
        .SLOT_CYC     (SLOT_CYC)
    ) seq_i (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .start_i  (start_s),
        .word_i   (code_word_i),
        .pulse_o  (tx_p_o),
        .active_o (burst_active_o)
    );

    assign tx_n_o = 1'b0;

    // R8
    quiet_outside_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !burst_active_o |-> !tx_p_o);

    // R5
    burst_open_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(burst_active_o) |-> tx_p_o);

    // R5
    burst_close_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(burst_active_o) |-> $past(tx_p_o));

endmodule

// File: tb/flp_burst_gen_tb_top.sv
module flp_burst_gen_tb_top;
    localparam int NB  = 14;
    localparam int PW  = 2;
    localparam int DO  = 6;
    localparam int SL  = 12;
    localparam int PER = 240;
    localparam int LEN = NB * SL + PW;

    logic clk = 1'b0;
    logic rst_ni = 1'b0;
    logic en = 1'b0;
    logic [NB-1:0] word = '0;
    logic txp, txn, act;

    always #10 clk = ~clk;

    flp_burst_gen #(
        .WORD_BITS (NB), .PULSE_CYC (PW), .DATA_OFS_CYC (DO),
        .SLOT_CYC (SL), .PERIOD_CYC (PER)
    ) dut_i (
        .clk_i (clk), .rst_ni (rst_ni), .enable_i (en), .code_word_i (word),
        .tx_p_o (txp), .tx_n_o (txn), .burst_active_o (act)
    );

    int checks = 0, errors = 0;
    bit done = 0;
    int mk = -1, mcnt = 0;
    logic [NB-1:0] mword = '0;
    bit prev_act = 0, prev_p = 0, en_cont = 0, dis_done = 0;
    longint cyc = 0, last_rise = -1;
    int pcount = 0, falls = 0, falls_at_dis = 0;
    logic [NB-1:0] dir [6] = '{14'h0000, 14'h3FFF, 14'h1555, 14'h2AAA, 14'h0001, 14'h2000};

    function automatic bit exp_pulse(int k, logic [NB-1:0] w);
        int s, p;
        if (k < 0) return 1'b0;
        s = k / SL;
        p = k % SL;
        if (p < PW) return 1'b1;
        if (s < NB && w[s] && p >= DO && p < DO + PW) return 1'b1;
        return 1'b0;
    endfunction

    task automatic chk(bit ok, string tag, longint a, longint e);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s at cycle %0d: actual %0d expected %0d", tag, cyc, a, e);
        end
    endtask

    task automatic step_model();
        bit st;
        cyc++;
        st = en && (mcnt == 0);
        if (mcnt == 0 && !en) mcnt = 0;
        else mcnt = (mcnt == PER - 1) ? 0 : mcnt + 1;
        if (mk < 0) begin
            if (st) begin
                mk = 0;
                mword = word;
            end
        end else begin
            mk++;
            if (mk == LEN) mk = -1;
        end
    endtask

    task automatic compare();
        bit ep;
        string t;
        t = (mk >= 0) ? "R5" : (en ? "R6" : "R7");
        chk(act == (mk >= 0), t, act, mk >= 0);
        ep = exp_pulse(mk, mword);
        t = (mk < 0) ? "R8" : ((mk % SL < PW) ? "R2" : "R3/R4");
        chk(txp == ep, t, txp, ep);
        chk(txn == 1'b0, "R8", txn, 0);
        if (act && !prev_act) begin
            if (last_rise >= 0 && en_cont) chk(cyc - last_rise == PER, "R6", cyc - last_rise, PER);
            last_rise = cyc;
            en_cont = 1;
            pcount = 0;
        end
        if (act && txp && !prev_p) pcount++;
        if (!act && prev_act) begin
            falls++;
            chk(pcount == NB + 1 + $countones(mword), "R9", pcount, NB + 1 + $countones(mword));
            chk(pcount >= 15 && pcount <= 30, "R9", pcount, 15);
        end
        if (!en) en_cont = 0;
        prev_act = act;
        prev_p = txp;
    endtask

    task automatic drive(int mode);
        case (mode)
            0: begin
                en = 1'b1;
                word = (mk < 0) ? dir[falls % 6] : NB'($urandom);
            end
            1: begin
                if (!dis_done && mk == 50) begin
                    en = 1'b0;
                    dis_done = 1;
                    falls_at_dis = falls;
                end else if (!dis_done) begin
                    en = 1'b1;
                end
                word = NB'($urandom);
            end
            default: begin
                if ($urandom % 200 == 0) en = ~en;
                word = NB'($urandom);
            end
        endcase
    endtask

    task automatic run(int n, int mode);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            step_model();
            compare();
            drive(mode);
        end
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            errors++;
            $display("FAIL R6 watchdog: actual hung expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        // R1: reset state
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(act == 1'b0, "R1", act, 0);
            chk(txp == 1'b0, "R1", txp, 0);
            chk(txn == 1'b0, "R1", txn, 0);
        end
        rst_ni = 1'b1;
        en = 1'b1;
        word = dir[0];
        run(8 * PER, 0);
        run(3 * PER, 1);
        // R7: the interrupted burst ended once and nothing followed
        chk(dis_done && (falls - falls_at_dis == 1) && !act, "R7", falls - falls_at_dis, 1);
        run(8000, 2);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule